// File: doc/BRIEF.md
# Trigger Event and Bunch Identifier Counters

This block keeps the two identifiers that a front-end readout node uses to label its data. Both run on the common machine clock, nominally 40 MHz with a 25 ns crossing period. The bunch identifier advances on every clock cycle, and an orbit reset strobe that arrives once per orbit clears it. The event identifier advances on each trigger-accept pulse. An event-counter reset strobe, issued on request after a malfunction, clears it.

On every trigger accept the block captures a tag pair. The pair holds the event identifier from before the increment and the bunch identifier of the accepting cycle. The block pushes the pair into a small first-in first-out queue that has a valid/ready output handshake. Downstream logic pops one tag per event and attaches it to the event data. If an accept arrives while the queue is full, the block drops that tag and raises an overflow flag. The flag stays set until reset.

Top module: `trig_id_tagger`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `bunch_id` and `event_id` are 0, `tag_valid` is 0 and `tag_overflow` is 0.
- R2: On each rising clock edge with `bcr_strobe` low, `bunch_id` becomes its previous value plus one, modulo 2^BUNCH_W (4096 by default), so 4095 is followed by 0.
- R3: On an edge where `bcr_strobe` was high, `bunch_id` becomes 0, even though an increment would otherwise happen in that cycle.
- R4: On an edge where `accept` was high and `ecr_strobe` was low, `event_id` becomes its previous value plus one, modulo 2^EVT_W. With `accept` and `ecr_strobe` both low, `event_id` keeps its value.
- R5: On an edge where `ecr_strobe` was high, `event_id` becomes 0, whether or not `accept` was high in that cycle.
- R6: An accept in a cycle captures a tag whose `tag_evt` field is the `event_id` of that cycle (the value before the increment) and whose `tag_bunch` field is the `bunch_id` of that cycle. If the queue was empty, the tag is presented with `tag_valid` high from the next cycle on.
- R7: The queue holds up to QDEPTH tags (16 by default) and presents them in accept order. A tag is removed on an edge where `tag_valid` and `tag_ready` are both high. `tag_valid` is low exactly when the queue is empty.
- R8: An accept that arrives while the queue holds QDEPTH tags is dropped, even if a pop happens in the same cycle. The stored tags stay unchanged, and `tag_overflow` rises on the next edge and stays high until reset.
- R9: While `tag_valid` is high and `tag_ready` is low, the presented tag and `tag_valid` stay unchanged on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcr_strobe | input | 1 | Orbit reset strobe for the bunch identifier |
| ecr_strobe | input | 1 | Event-counter reset strobe |
| accept | input | 1 | Trigger-accept pulse, one cycle per event |
| bunch_id | output | BUNCH_W (12) | Current bunch identifier |
| event_id | output | EVT_W (24) | Current event identifier |
| tag_valid | output | 1 | Queue head holds a tag |
| tag_ready | input | 1 | Consumer takes the head tag on this edge |
| tag_evt | output | EVT_W (24) | Event identifier of the head tag |
| tag_bunch | output | BUNCH_W (12) | Bunch identifier of the head tag |
| tag_overflow | output | 1 | Sticky flag: a tag was dropped on a full queue |

## Verification
The assertions check the local rules on every cycle:
- the counter step, hold and clear, including the case where a strobe wins over an increment;
- the capture of a tag into an empty queue;
- the occupancy that is kept when a push meets a full queue;
- the sticky overflow flag;
- a head tag that stays unchanged while stalled.

Only the bench's scenarios can show:
- that whole sequences of tags leave the queue in accept order after the queue has been filled and drained;
- the wrap of the bunch identifier after 4096 cycles;
- the wrap of the event identifier, checked on a narrow-width instance;
- that dropped tags leave the stored entries untouched.

// File: rtl/trig_id_pkg.sv
package trig_id_pkg;

  localparam int unsigned DEF_BUNCH_W = 12;
  localparam int unsigned DEF_EVT_W   = 24;
  localparam int unsigned DEF_QDEPTH  = 16;

  // Increment modulo 2^w; widths up to 32 bits.
  function automatic logic [31:0] mod_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction

  // Next pointer in a ring of n slots.
  function automatic logic [31:0] ring_next(input logic [31:0] p, input int unsigned n);
    return (p == n - 1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/id_counter.sv
module id_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  import trig_id_pkg::*;

  logic [W-1:0] value_q;
  logic [W-1:0] value_nxt;
  logic         do_clear;
  logic         do_step;

  assign do_clear = clr;
  assign do_step  = inc && !clr;

  always_comb begin
    value_nxt = value_q;
    if (do_clear)     value_nxt = '0;
    else if (do_step) value_nxt = W'(mod_inc(32'(value_q), W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_nxt;
  end

  assign value = value_q;

  // R2 / R4: step by one with wrap
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (value == W'($past(value) + 1'b1)));
  // R4: hold without increment
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(value));
  // R3 / R5: strobe clears and wins
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));

endmodule

// File: rtl/tag_fifo.sv
module tag_fifo #(
  parameter int unsigned TW    = 36,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [TW-1:0] out_data,
  output logic          overflow
);
  import trig_id_pkg::*;

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          ovf_q;

  logic full, empty, push_ok, push_drop, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = !empty && out_ready;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ring_next(32'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ring_next(32'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_drop) ovf_q <= 1'b1;
    end
  end

  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign overflow  = ovf_q;

  // R8: a dropped push does not change occupancy without a pop
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok) |=> (count == $past(count) && overflow));
  // R8: overflow is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7: occupancy never exceeds depth
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R9: stalled head is stable
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/trig_id_tagger.sv
module trig_id_tagger #(
  parameter int unsigned BUNCH_W = trig_id_pkg::DEF_BUNCH_W,
  parameter int unsigned EVT_W   = trig_id_pkg::DEF_EVT_W,
  parameter int unsigned QDEPTH  = trig_id_pkg::DEF_QDEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bcr_strobe,
  input  logic               ecr_strobe,
  input  logic               accept,
  output logic [BUNCH_W-1:0] bunch_id,
  output logic [EVT_W-1:0]   event_id,
  output logic               tag_valid,
  input  logic               tag_ready,
  output logic [EVT_W-1:0]   tag_evt,
  output logic [BUNCH_W-1:0] tag_bunch,
  output logic               tag_overflow
);

  localparam int unsigned TW = EVT_W + BUNCH_W;

  logic [TW-1:0] cap_tag;
  logic [TW-1:0] head_tag;

  id_counter #(.W(BUNCH_W)) u_bunch (
    .clk(clk), .rst_n(rst_n), .clr(bcr_strobe), .inc(1'b1), .value(bunch_id)
  );

  id_counter #(.W(EVT_W)) u_event (
    .clk(clk), .rst_n(rst_n), .clr(ecr_strobe), .inc(accept), .value(event_id)
  );

  // Tag uses the values present in the accept cycle (pre-increment).
  assign cap_tag = {event_id, bunch_id};

  tag_fifo #(.TW(TW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_data(cap_tag),
    .out_valid(tag_valid), .out_ready(tag_ready),
    .out_data(head_tag), .overflow(tag_overflow)
  );

  assign tag_evt   = head_tag[TW-1:BUNCH_W];
  assign tag_bunch = head_tag[BUNCH_W-1:0];

  // R6: capture into an empty queue is presented next cycle
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tag_valid) |=>
      (tag_valid && tag_evt == $past(event_id) && tag_bunch == $past(bunch_id)));

endmodule

// File: tb/trig_id_tagger_bench.sv
`timescale 1ns/1ps
module trig_id_tagger_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, bcr, ecr, acc, rdy;
  logic [11:0] bunch_id, tag_bunch;
  logic [23:0] event_id, tag_evt;
  logic        tag_valid, tag_overflow;

  logic [11:0] n_bunch, n_tbunch;
  logic [3:0]  n_evt, n_tevt;
  logic        n_valid, n_ovf;

  trig_id_tagger u_trig_id_tagger (
    .clk(clk), .rst_n(rst_n), .bcr_strobe(bcr), .ecr_strobe(ecr), .accept(acc),
    .bunch_id(bunch_id), .event_id(event_id), .tag_valid(tag_valid),
    .tag_ready(rdy), .tag_evt(tag_evt), .tag_bunch(tag_bunch),
    .tag_overflow(tag_overflow)
  );

  // Narrow event width to reach the event-identifier wrap (R4)
  trig_id_tagger #(.EVT_W(4)) u_narrow (
    .clk(clk), .rst_n(rst_n), .bcr_strobe(bcr), .ecr_strobe(ecr), .accept(acc),
    .bunch_id(n_bunch), .event_id(n_evt), .tag_valid(n_valid),
    .tag_ready(1'b1), .tag_evt(n_tevt), .tag_bunch(n_tbunch),
    .tag_overflow(n_ovf)
  );

  int checks = 0;
  int failures = 0;

  // reference state
  int unsigned mb, me;
  logic [35:0] q [16];
  int qh, qc;
  bit movf;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(bunch_id == mb[11:0], "R2/R3 bunch_id", bunch_id, mb);
    chk(event_id == me[23:0], "R4/R5 event_id", event_id, me);
    chk(n_evt == me[3:0], "R4 narrow wrap", n_evt, me[3:0]);
    chk(tag_valid == (qc > 0), "R7 tag_valid", tag_valid, qc > 0);
    if (qc > 0) begin
      chk(tag_evt == q[qh][35:12], "R6/R7 tag_evt", tag_evt, q[qh][35:12]);
      chk(tag_bunch == q[qh][11:0], "R6/R7 tag_bunch", tag_bunch, q[qh][11:0]);
    end
    chk(tag_overflow == movf, "R8 overflow", tag_overflow, movf);
  endtask

  // Called at a negedge; drives, lets one edge pass, checks at next negedge.
  task automatic step(input logic b, input logic e, input logic a, input logic r);
    int qh0, qc0;
    bcr = b; ecr = e; acc = a; rdy = r;
    @(posedge clk);
    qh0 = qh; qc0 = qc;
    if (a) begin
      if (qc0 < 16) q[(qh0 + qc0) % 16] = {me[23:0], mb[11:0]};
      else movf = 1'b1;
    end
    if (qc0 > 0 && r) begin qh = (qh0 + 1) % 16; qc = qc0 - 1; end
    if (a && qc0 < 16) qc = qc + 1;
    mb = b ? 0 : ((mb + 1) % 4096);
    me = e ? 0 : (a ? ((me + 1) % (1 << 24)) : me);
    @(negedge clk);
    compare_all();
  endtask

  // stimulus vectors {bcr, ecr, accept, ready}
  localparam int NV = 24;
  localparam logic [3:0] VEC [NV] = '{
    4'b0010, 4'b0000, 4'b0011, 4'b0001, 4'b0010, 4'b0010, 4'b0000, 4'b0001,
    4'b1000, 4'b0000, 4'b1010, 4'b0001, 4'b0100, 4'b0011, 4'b0110, 4'b0001,
    4'b0011, 4'b0011, 4'b1111, 4'b0001, 4'b0000, 4'b0010, 4'b0001, 4'b0001
  };

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bcr = 0; ecr = 0; acc = 0; rdy = 0;
    mb = 0; me = 0; qh = 0; qc = 0; movf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(bunch_id == 0, "R1 bunch reset", bunch_id, 0);
    chk(event_id == 0, "R1 event reset", event_id, 0);
    chk(tag_valid == 0, "R1 valid reset", tag_valid, 0);
    chk(tag_overflow == 0, "R1 overflow reset", tag_overflow, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);   // first cycle after reset: counters step from 0

    // table walk
    for (int i = 0; i < NV; i++) step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // R5: ecr with accept: tag keeps old event id, counter goes to 0
    step(0, 0, 1, 1); step(0, 0, 1, 1);
    step(0, 1, 1, 0);
    chk(event_id == 0, "R5 ecr wins", event_id, 0);
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);

    // R8/R9: fill with ready low, 18 accepts, then stall
    for (int i = 0; i < 18; i++) step(0, 0, 1, 0);
    chk(tag_overflow == 1, "R8 overflow set", tag_overflow, 1);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R8: push on full with pop in same cycle is still dropped
    step(0, 0, 1, 1);
    for (int i = 0; i < 18; i++) step(0, 0, 0, 1);
    chk(tag_valid == 0, "R7 drained", tag_valid, 0);
    chk(tag_overflow == 1, "R8 sticky", tag_overflow, 1);

    // R2: bunch identifier wrap
    step(1, 0, 0, 1);
    for (int i = 0; i < 4100; i++) step(0, 0, (i == 4094), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule